// File: doc/BRIEF.md
# Memory-Mapped Polled Character Channel

This block connects one character device pair to a CPU bus as a window of four word addresses that starts at a 4-aligned base. A keyboard-like source on the device side hands over one 8-bit code per strobe. The code sits in a single-word receive buffer until the CPU fetches it. In the other direction the CPU drops a word into a single-word transmit buffer. Its low byte is offered to an output device, which takes it with an acknowledge pulse.

Software can run the channel in two ways. It can sample the status word in a wait loop, or it can enable interrupts and react to a level request. While the request is up, the first word of the window reads as a fixed device code that identifies the source. Reads return data combinationally in the cycle the access is presented. Writes and side effects take hold at the next rising clock edge.

Window layout (offset from base): +0 interrupt code word (read-only), +1 receive word (read-only), +2 transmit word, +3 control/status word.

Top module: `pio_channel`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x0002, the receive and transmit words read 0, the code word reads 0, `irq` is 0 and `out_valid` is 0.
- R2: An access responds only when `cpu_sel` is high and the address lies in base..base+3. At any other address a read returns 0 and a write changes nothing.
- R3: A `kbd_strobe` loads `kbd_code` into the receive word and sets status bit 0 (receive ready) from the next cycle.
- R4: A read of base+1 returns the held character, zero-extended, in the same cycle. Status bit 0 is clear from the next cycle.
- R5: A strobe that arrives while bit 0 is set overwrites the receive word and sets status bit 2 (overrun). Bit 2 stays set until the CPU writes base+3 with bit 2 = 1. Writing 0 there leaves it set.
- R6: A write to base+2 stores the full word, clears status bit 1 (transmit empty), raises `out_valid` and drives its low 8 bits on `out_code`. An `out_ack` pulse sets bit 1 again and drops `out_valid`.
- R7: Status bits 4 (receive interrupt enable) and 5 (transmit interrupt enable) are written and read back through base+3. All other status bits read as 0 and ignore writes.
- R8: `irq` is high exactly when (bit 4 and bit 0) or (bit 5 and bit 1). While it is high, base+0 reads DEV_CODE (default 0x00A5); otherwise base+0 reads 0.
- R9: Writes to base+0 and base+1 have no effect.
- R10: A strobe in the same cycle as a read of base+1 keeps the new character. Bit 0 stays set and bit 2 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (16) | Word address |
| cpu_wdata | input | DATA_W (16) | Write data |
| cpu_rdata | output | DATA_W (16) | Read data, combinational |
| irq | output | 1 | Level interrupt request |
| kbd_strobe | input | 1 | One-cycle character strobe |
| kbd_code | input | CHAR_W (8) | Character code |
| out_code | output | CHAR_W (8) | Character offered to the output device |
| out_valid | output | 1 | Transmit word holds an untaken character |
| out_ack | input | 1 | Output device took the character |

## Verification
A vector table drives several patterns. One is a single character that is fetched, which separates the set and clear paths of the ready flag. Another is two characters back to back, which separates a plain load from an overrun and shows that the second code wins. Status writes with the overrun bit at 0 and then at 1 tell a true write-one-to-clear apart from a plain store. Writes with all bits set check that only the enable bits stick. Accesses just outside the window and writes to the read-only words show whether the decode leaks. Directed tests then cover the read that collides with a strobe, the transmit handshake, and a reset in mid-run.

// File: rtl/pio_pkg.sv
// Package pio_pkg: shared offsets and status bit positions for the channel.
// Assumes a four-word window, so the offset is two address bits.
package pio_pkg;
    typedef enum logic [1:0] {
        OFF_CODE = 2'd0,
        OFF_RX   = 2'd1,
        OFF_TX   = 2'd2,
        OFF_CSR  = 2'd3
    } win_off_e;

    localparam int unsigned SB_RX_RDY  = 0;
    localparam int unsigned SB_TX_MT   = 1;
    localparam int unsigned SB_OVR     = 2;
    localparam int unsigned SB_RX_IE   = 4;
    localparam int unsigned SB_TX_IE   = 5;
endpackage

// File: rtl/pio_decode.sv
// Module pio_decode: matches a bus address against a 4-aligned base and
// returns the word offset inside the four-word window.
// Assumes BASE_ADDR has its two low bits at zero.
module pio_decode #(
    parameter int unsigned    ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output pio_pkg::win_off_e off
);
    // Window match on the upper address bits, offset from the lower two.
    always_comb begin
        hit = sel && (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
        off = pio_pkg::win_off_e'(addr[1:0]);
    end
endmodule

// File: rtl/pio_rx_buf.sv
// Module pio_rx_buf: single-word receive buffer with ready and overrun flags.
// Assumes the strobe is one cycle wide per character. A strobe beats a
// same-cycle take, and overrun setting beats a same-cycle clear.
module pio_rx_buf #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] code,
    input  logic              take,
    input  logic              ovr_clr,
    output logic [CHAR_W-1:0] data,
    output logic              rdy,
    output logic              ovr
);
    // Character register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            rdy  <= 1'b0;
        end else if (strobe) begin
            data <= code;
            rdy  <= 1'b1;
        end else if (take) begin
            rdy  <= 1'b0;
        end
    end

    // Sticky overrun flag, cleared by a write-one from the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (strobe && rdy && !take)
            ovr <= 1'b1;
        else if (ovr_clr)
            ovr <= 1'b0;
    end

    AST_RX_RDY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> rdy); // R3
    AST_RX_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !strobe) |=> !rdy); // R4
    AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr); // R5
endmodule

// File: rtl/pio_tx_buf.sv
// Module pio_tx_buf: single-word transmit buffer with an empty flag.
// Assumes the acknowledge is a pulse. A same-cycle CPU load beats it.
module pio_tx_buf #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic [DATA_W-1:0] data,
    output logic              empty
);
    // Buffer register and empty flag handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (load) begin
            data  <= wdata;
            empty <= 1'b0;
        end else if (ack) begin
            empty <= 1'b1;
        end
    end

    AST_TX_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!empty && data == $past(wdata))); // R6
    AST_TX_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !load) |=> empty); // R6
endmodule

// File: rtl/pio_channel.sv
// Module pio_channel: four-word memory-mapped character channel with polled
// status and a level interrupt. Reads are combinational and writes act at
// the clock edge. Assumes a 4-aligned BASE_ADDR and DATA_W >= 6.
module pio_channel #(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 16,
    parameter int unsigned       CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
    parameter logic [DATA_W-1:0] DEV_CODE  = 16'h00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq,
    input  logic              kbd_strobe,
    input  logic [CHAR_W-1:0] kbd_code,
    output logic [CHAR_W-1:0] out_code,
    output logic              out_valid,
    input  logic              out_ack
);
    import pio_pkg::*;

    localparam int unsigned PAD_W = DATA_W - CHAR_W;

    logic              hit;
    win_off_e          off;
    logic              rd_rx, wr_tx, wr_csr;
    logic [CHAR_W-1:0] rx_data;
    logic              rx_rdy, rx_ovr;
    logic [DATA_W-1:0] tx_data;
    logic              tx_empty;
    logic              ie_rx, ie_tx;
    logic [DATA_W-1:0] status;

    pio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .sel (cpu_sel),
        .addr(cpu_addr),
        .hit (hit),
        .off (off)
    );

    // Access qualifiers per window word.
    always_comb begin
        rd_rx  = hit && !cpu_we && (off == OFF_RX);
        wr_tx  = hit &&  cpu_we && (off == OFF_TX);
        wr_csr = hit &&  cpu_we && (off == OFF_CSR);
    end

    pio_rx_buf #(.CHAR_W(CHAR_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (kbd_strobe),
        .code   (kbd_code),
        .take   (rd_rx),
        .ovr_clr(wr_csr && cpu_wdata[SB_OVR]),
        .data   (rx_data),
        .rdy    (rx_rdy),
        .ovr    (rx_ovr)
    );

    pio_tx_buf #(.DATA_W(DATA_W)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wr_tx),
        .wdata(cpu_wdata),
        .ack  (out_ack),
        .data (tx_data),
        .empty(tx_empty)
    );

    // Interrupt enable bits held in the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_rx <= 1'b0;
            ie_tx <= 1'b0;
        end else if (wr_csr) begin
            ie_rx <= cpu_wdata[SB_RX_IE];
            ie_tx <= cpu_wdata[SB_TX_IE];
        end
    end

    // Status word assembly; unassigned bits stay zero.
    always_comb begin
        status            = '0;
        status[SB_RX_RDY] = rx_rdy;
        status[SB_TX_MT]  = tx_empty;
        status[SB_OVR]    = rx_ovr;
        status[SB_RX_IE]  = ie_rx;
        status[SB_TX_IE]  = ie_tx;
    end

    // Level request from enabled ready conditions; device side outputs.
    always_comb begin
        irq       = (ie_rx && rx_rdy) || (ie_tx && tx_empty);
        out_code  = tx_data[CHAR_W-1:0];
        out_valid = !tx_empty;
    end

    // Read multiplexer over the four window words.
    always_comb begin
        cpu_rdata = '0;
        if (hit && !cpu_we) begin
            unique case (off)
                OFF_CODE: cpu_rdata = irq ? DEV_CODE : '0;
                OFF_RX:   cpu_rdata = {{PAD_W{1'b0}}, rx_data};
                OFF_TX:   cpu_rdata = tx_data;
                OFF_CSR:  cpu_rdata = status;
            endcase
        end
    end

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> (cpu_rdata == '0)); // R2
    AST_IRQ_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_strobe && ie_rx && !wr_csr) |=> irq); // R8
endmodule

// File: tb/pio_channel_bench.sv
// Bench for pio_channel: a vector table walked by one loop, then directed
// tests for the colliding read, the transmit handshake and reset.
module pio_channel_bench;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_KB = 2'd2, OP_AK = 2'd3;
    localparam int NV = 39;
    // {op, addr, data, expected read, requirement number}
    localparam logic [53:0] VEC [NV] = '{
        {OP_RD, 16'h0043, 16'h0000, 16'h0002, 4'd1},  // R1 status after reset
        {OP_RD, 16'h0041, 16'h0000, 16'h0000, 4'd1},  // R1 rx word
        {OP_RD, 16'h0040, 16'h0000, 16'h0000, 4'd1},  // R1 code word
        {OP_KB, 16'h0000, 16'h0031, 16'h0000, 4'd3},  // R3 char in
        {OP_RD, 16'h0043, 16'h0000, 16'h0003, 4'd3},  // R3 ready set
        {OP_RD, 16'h0041, 16'h0000, 16'h0031, 4'd4},  // R4 fetch
        {OP_RD, 16'h0043, 16'h0000, 16'h0002, 4'd4},  // R4 ready cleared
        {OP_KB, 16'h0000, 16'h0041, 16'h0000, 4'd5},  // R5 first
        {OP_KB, 16'h0000, 16'h0042, 16'h0000, 4'd5},  // R5 second, overrun
        {OP_RD, 16'h0043, 16'h0000, 16'h0007, 4'd5},  // R5 overrun flag
        {OP_RD, 16'h0041, 16'h0000, 16'h0042, 4'd5},  // R5 newest wins
        {OP_RD, 16'h0043, 16'h0000, 16'h0006, 4'd5},  // R5 sticky
        {OP_WR, 16'h0043, 16'h0000, 16'h0000, 4'd5},  // R5 write 0
        {OP_RD, 16'h0043, 16'h0000, 16'h0006, 4'd5},  // R5 still set
        {OP_WR, 16'h0043, 16'h0004, 16'h0000, 4'd5},  // R5 write 1
        {OP_RD, 16'h0043, 16'h0000, 16'h0002, 4'd5},  // R5 cleared
        {OP_WR, 16'h0042, 16'h1234, 16'h0000, 4'd6},  // R6 tx write
        {OP_RD, 16'h0043, 16'h0000, 16'h0000, 4'd6},  // R6 busy
        {OP_RD, 16'h0042, 16'h0000, 16'h1234, 4'd6},  // R6 full word kept
        {OP_AK, 16'h0000, 16'h0000, 16'h0000, 4'd6},  // R6 ack
        {OP_RD, 16'h0043, 16'h0000, 16'h0002, 4'd6},  // R6 empty again
        {OP_WR, 16'h0043, 16'hFFFB, 16'h0000, 4'd7},  // R7 all bits but overrun
        {OP_RD, 16'h0043, 16'h0000, 16'h0032, 4'd7},  // R7 only enables stick
        {OP_RD, 16'h0040, 16'h0000, 16'h00A5, 4'd8},  // R8 code with tx irq
        {OP_WR, 16'h0043, 16'h0010, 16'h0000, 4'd8},  // R8 rx enable only
        {OP_RD, 16'h0040, 16'h0000, 16'h0000, 4'd8},  // R8 no request
        {OP_KB, 16'h0000, 16'h0055, 16'h0000, 4'd8},  // R8 char raises irq
        {OP_RD, 16'h0040, 16'h0000, 16'h00A5, 4'd8},  // R8 code
        {OP_RD, 16'h0041, 16'h0000, 16'h0055, 4'd8},  // R8 fetch
        {OP_RD, 16'h0040, 16'h0000, 16'h0000, 4'd8},  // R8 request gone
        {OP_WR, 16'h0041, 16'h00EE, 16'h0000, 4'd9},  // R9 write rx word
        {OP_WR, 16'h0040, 16'h1111, 16'h0000, 4'd9},  // R9 write code word
        {OP_RD, 16'h0041, 16'h0000, 16'h0055, 4'd9},  // R9 rx unchanged
        {OP_RD, 16'h0043, 16'h0000, 16'h0012, 4'd9},  // R9 status unchanged
        {OP_WR, 16'h0047, 16'h0030, 16'h0000, 4'd2},  // R2 past window
        {OP_WR, 16'h0003, 16'h0030, 16'h0000, 4'd2},  // R2 alias offset
        {OP_RD, 16'h0043, 16'h0000, 16'h0012, 4'd2},  // R2 no effect
        {OP_RD, 16'h0047, 16'h0000, 16'h0000, 4'd2},  // R2 miss reads 0
        {OP_RD, 16'h0003, 16'h0000, 16'h0000, 4'd2}   // R2 miss reads 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq, kbd_strobe = 1'b0, out_valid, out_ack = 1'b0;
    logic [7:0]  kbd_code = '0, out_code;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pio_channel u_pio_channel (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq), .kbd_strobe(kbd_strobe), .kbd_code(kbd_code),
        .out_code(out_code), .out_valid(out_valid), .out_ack(out_ack)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_sel = 0; cpu_we = 0; kbd_strobe = 0; out_ack = 0;
    endtask

    // One operation per cycle: drive after the falling edge, sample 1 ns later.
    task automatic step(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                        input logic [15:0] exp, input int rq);
        @(negedge clk);
        idle();
        case (op)
            OP_WR: begin cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; end
            OP_RD: begin cpu_sel = 1; cpu_addr = a; end
            OP_KB: begin kbd_strobe = 1; kbd_code = d[7:0]; end
            default: out_ack = 1;
        endcase
        #1;
        if (op == OP_RD) chk($sformatf("R%0d", rq), cpu_rdata, exp);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
        step(OP_RD, a, 16'h0, exp, 0);
        if (cpu_rdata !== exp) $display("  (check above was %s)", req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 out_valid", {15'b0, out_valid}, 16'h0);

        for (int i = 0; i < NV; i++)
            step(VEC[i][53:52], VEC[i][51:36], VEC[i][35:20], VEC[i][19:4], int'(VEC[i][3:0]));

        // R8: rx enable set, char pending -> irq high
        step(OP_KB, 16'h0, 16'h0010, 16'h0, 8);
        @(negedge clk); idle(); #1;
        chk("R8 irq level", {15'b0, irq}, 16'h1);

        // R10: strobe colliding with a fetch
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = 16'h0041; kbd_strobe = 1; kbd_code = 8'h20;
        #1 chk("R10 old char returned", cpu_rdata, 16'h0010);
        rd_chk("R10", 16'h0043, 16'h0013);
        chk("R10 ready kept, no overrun", cpu_rdata, 16'h0013);
        rd_chk("R10", 16'h0041, 16'h0020);
        chk("R10 new char kept", cpu_rdata, 16'h0020);

        // R6: device side handshake
        step(OP_WR, 16'h0042, 16'hABC7, 16'h0, 6);
        @(negedge clk); idle(); #1;
        chk("R6 out_valid", {15'b0, out_valid}, 16'h1);
        chk("R6 out_code", {8'h0, out_code}, 16'h00C7);
        step(OP_AK, 16'h0, 16'h0, 16'h0, 6);
        @(negedge clk); idle(); #1;
        chk("R6 out_valid after ack", {15'b0, out_valid}, 16'h0);

        // R1: reset in mid-run with a pending char and a busy transmitter
        step(OP_KB, 16'h0, 16'h0077, 16'h0, 1);
        step(OP_WR, 16'h0042, 16'h0099, 16'h0, 1);
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        chk("R1 irq after reset", {15'b0, irq}, 16'h0);
        chk("R1 out_valid after reset", {15'b0, out_valid}, 16'h0);
        chk("R1 out_code after reset", {8'h0, out_code}, 16'h0);
        step(OP_RD, 16'h0043, 16'h0, 16'h0002, 1);
        step(OP_RD, 16'h0041, 16'h0, 16'h0000, 1);
        step(OP_RD, 16'h0042, 16'h0, 16'h0000, 1);

        @(negedge clk); idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule